// File: doc/BRIEF.md
# Burst SRAM Address and Burst Control

This block is the clocked front end of a burst-capable synchronous SRAM. It looks at two active-low address strobes: one driven by a processor and one driven by a cache controller. On a clock edge where a strobe is accepted, it captures the external word address and the three chip enables. The two low address bits go into a 2-bit beat counter, and the upper bits are held for the rest of the burst.

After the load, each edge with the active-low advance input asserted steps the counter. The order is linear or interleaved, set by a static order input. The block presents the current internal word address, a registered select flag and a one-cycle pulse that marks each new address load. The memory array and the data path sit downstream and use these outputs.

The processor strobe has priority over the controller strobe. The processor strobe only counts while chip enable 1 is asserted, and the controller strobe has no such gate. Chip enables are looked at only at the moment an address loads.

Top module: `burst_addr_ctrl`

## Requirements
- R1: On a rising edge where a strobe is accepted, `word_addr_o` takes the full value of `addr_i` from the following cycle.
- R2: When both strobes are low in the same cycle with `en1_n` low, the address is loaded once and the access counts as a processor access.
- R3: The processor strobe is ignored while `en1_n` is high: nothing loads unless `strb_ctrl_n` is also low. The controller strobe loads whatever the state of `en1_n`.
- R4: `sel_o` becomes 1 after a load only if `en1_n`=0, `en2`=1 and `en3_n`=0 at that edge, and 0 otherwise. The enables have no effect on edges with no load.
- R5: With `order_il`=1 (interleaved), the two low address bits equal the start value XOR the beat count.
- R6: With `order_il`=0 (linear), the two low address bits equal the start value plus the beat count, modulo 4.
- R7: Bits `[AW-1:2]` stay at their captured value for the whole burst. After four beats the low bits wrap back to the start value.
- R8: On an edge with no accepted strobe and `adv_n`=1, `word_addr_o` and `sel_o` hold their values.
- R9: While `rst` is high at a clock edge, `word_addr_o`, `sel_o` and `new_acc_o` are cleared to 0.
- R10: The beat counter advances on an `adv_n`=0 edge only while `sel_o` is 1. A deselected access does not step.
- R11: `new_acc_o` is 1 for exactly the one cycle after each edge that loads an address, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | External word address |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| word_addr_o | output | AW | Current internal word address |
| sel_o | output | 1 | Registered device-select flag |
| new_acc_o | output | 1 | One-cycle pulse after each address load |

## Verification
The hardest case to reach is one where the two strobes and chip enable 1 disagree. A processor strobe with `en1_n` high must leave everything untouched, while a controller strobe in the same state must load a deselected access that then refuses to advance. The directed tasks drive each of these combinations on its own edge. Between strobes they change `addr_i` and the enables, so a wrong gate or a late sample shows up on `word_addr_o` or `sel_o`. Both burst orders are walked from odd start values through a full wrap, because from those starts the linear and interleaved sequences differ.

// File: rtl/bac_pkg.sv
package bac_pkg;

    localparam int LOW_BITS = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    function automatic logic [LOW_BITS-1:0] beat_low(
        input logic [LOW_BITS-1:0] start,
        input logic [LOW_BITS-1:0] beat,
        input burst_order_e        ord
    );
        if (ord == ORD_INTERLEAVE)
            return start ^ beat;
        else
            return start + beat;
    endfunction

endpackage

// File: rtl/bac_load_decode.sv
module bac_load_decode (
    input  logic strb_proc_n,
    input  logic strb_ctrl_n,
    input  logic en1_n,
    input  logic en2,
    input  logic en3_n,
    output logic load,
    output logic proc_win,
    output logic sel_new
);
    // Processor strobe counts only with enable 1 active; it wins over the controller.
    always_comb begin
        proc_win = !strb_proc_n && !en1_n;
        load     = proc_win || !strb_ctrl_n;
        sel_new  = !en1_n && en2 && !en3_n;
    end

    always_comb begin
        if (proc_win) begin
            a_r3_proc_needs_en1: assert (!en1_n);
        end
    end
endmodule

// File: rtl/bac_beat_counter.sv
module bac_beat_counter
    import bac_pkg::*;
#(
    parameter int CW = LOW_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  burst_order_e  ord,
    output logic [CW-1:0] low_o
);
    typedef struct packed {
        logic [CW-1:0] start;
        logic [CW-1:0] beat;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start = load_val;
            st_d.beat  = '0;
        end else if (step) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb low_o = beat_low(st_q.start, st_q.beat, ord);

    // R10: without load or step the beat does not move
    a_r10_no_step_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(st_q.beat));
    // R1: a load restarts the beat at zero
    a_r1_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load |=> (st_q.beat == '0));
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import bac_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          strb_proc_n,
    input  logic          strb_ctrl_n,
    input  logic          en1_n,
    input  logic          en2,
    input  logic          en3_n,
    input  logic          adv_n,
    input  logic          order_il,
    output logic [AW-1:0] word_addr_o,
    output logic          sel_o,
    output logic          new_acc_o
);
    localparam int UW = AW - LOW_BITS;

    typedef struct packed {
        logic [UW-1:0] base;
        logic          sel;
        logic          nacc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                load, proc_win, sel_new, step;
    logic [LOW_BITS-1:0] low;
    burst_order_e        ord;

    bac_load_decode u_dec (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .en1_n       (en1_n),
        .en2         (en2),
        .en3_n       (en3_n),
        .load        (load),
        .proc_win    (proc_win),
        .sel_new     (sel_new)
    );

    always_comb begin
        ord  = burst_order_e'(order_il);
        step = !adv_n && st_q.sel;
    end

    bac_beat_counter #(.CW(LOW_BITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (addr_i[LOW_BITS-1:0]),
        .step     (step),
        .ord      (ord),
        .low_o    (low)
    );

    always_comb begin
        st_d      = st_q;
        st_d.nacc = load;
        if (load) begin
            st_d.base = addr_i[AW-1:LOW_BITS];
            st_d.sel  = sel_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        word_addr_o = {st_q.base, low};
        sel_o       = st_q.sel;
        new_acc_o   = st_q.nacc;
    end

    // R1: accepted strobe captures the full address
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctrl_n || (!strb_proc_n && !en1_n)) |=> (word_addr_o == $past(addr_i)));
    // R2: both strobes with enable 1 active selects according to enables
    a_r2_both_strobes: assert property (@(posedge clk) disable iff (rst)
        (!strb_proc_n && !strb_ctrl_n && !en1_n) |=> (sel_o == ($past(en2) && !$past(en3_n))));
    // R3: gated processor strobe alone loads nothing
    a_r3_proc_gated: assert property (@(posedge clk) disable iff (rst)
        (!strb_proc_n && en1_n && strb_ctrl_n) |=> !new_acc_o);
    // R7: upper bits fixed without a load
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_addr_o[AW-1:LOW_BITS]));
    // R8: idle edge holds address and select
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> ($stable(word_addr_o) && $stable(sel_o)));
    // R10: deselected burst does not step
    a_r10_desel_still: assert property (@(posedge clk) disable iff (rst)
        (!load && !sel_o) |=> $stable(word_addr_o));
    // R11: pulse only after a load
    a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
        new_acc_o |-> $past(load));
endmodule

// File: tb/tb_burst_addr_ctrl.sv
module tb_burst_addr_ctrl;
    localparam int AW = 21;
    localparam time TCLK = 10ns;
    localparam int WDOG = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1;
    logic          en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
    logic          adv_n = 1'b1, order_il = 1'b0;
    logic [AW-1:0] word_addr_o;
    logic          sel_o, new_acc_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(TCLK/2) clk = ~clk;

    burst_addr_ctrl #(.AW(AW)) dut (.*);

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, sample after it
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic idle_in();
        @(negedge clk);
        strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
    endtask

    task automatic t_reset();
        cyc(); cyc();
        chk("R9 addr", word_addr_o, '0);
        chk("R9 sel", sel_o, 0);
        chk("R9 pulse", new_acc_o, 0);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_linear();
        logic [AW-1:0] a = 21'h12345; // low bits 01
        logic [1:0] seq [5] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
        @(negedge clk);
        order_il = 0; addr_i = a; strb_ctrl_n = 0; en1_n = 0; en2 = 1; en3_n = 0;
        cyc();
        chk("R1 load", word_addr_o, a);
        chk("R4 sel", sel_o, 1);
        chk("R11 pulse high", new_acc_o, 1);
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            strb_ctrl_n = 1; adv_n = 0; addr_i = 21'h0AAAA;
            cyc();
            chk("R6 linear", word_addr_o, {a[AW-1:2], seq[i]});
            chk("R7 upper", word_addr_o[AW-1:2], a[AW-1:2]);
        end
        chk("R11 pulse low", new_acc_o, 0);
        idle_in();
    endtask

    task automatic t_interleave();
        logic [AW-1:0] a = 21'h1F0F3; // low bits 11
        logic [1:0] seq [5] = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd3};
        @(negedge clk);
        order_il = 1; addr_i = a; strb_proc_n = 0; en1_n = 0; en2 = 1; en3_n = 0;
        cyc();
        chk("R1 proc load", word_addr_o, a);
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            strb_proc_n = 1; adv_n = 0;
            cyc();
            chk("R5 interleave", word_addr_o, {a[AW-1:2], seq[i]});
        end
        chk("R7 wrap", word_addr_o, a);
        idle_in();
    endtask

    task automatic t_hold();
        logic [AW-1:0] keep = word_addr_o;
        @(negedge clk);
        addr_i = 21'h05555; en1_n = 1; en2 = 0; en3_n = 1; adv_n = 1;
        cyc(); cyc();
        chk("R8 hold addr", word_addr_o, keep);
        chk("R4 enables ignored", sel_o, 1);
        chk("R11 no pulse", new_acc_o, 0);
    endtask

    task automatic t_gate();
        logic [AW-1:0] keep = word_addr_o;
        logic [AW-1:0] b = 21'h0C002; // low bits 10
        @(negedge clk);
        addr_i = b; strb_proc_n = 0; en1_n = 1; en2 = 1; en3_n = 0;
        cyc();
        chk("R3 proc gated addr", word_addr_o, keep);
        chk("R3 proc gated pulse", new_acc_o, 0);
        @(negedge clk);
        strb_proc_n = 1; strb_ctrl_n = 0;
        cyc();
        chk("R3 ctrl ungated", word_addr_o, b);
        chk("R4 deselected", sel_o, 0);
        @(negedge clk);
        strb_ctrl_n = 1; adv_n = 0;
        cyc(); cyc();
        chk("R10 no advance", word_addr_o, b);
        idle_in();
    endtask

    task automatic t_prio();
        logic [AW-1:0] c = 21'h1ABC1;
        @(negedge clk);
        addr_i = c; strb_proc_n = 0; strb_ctrl_n = 0; en1_n = 0; en2 = 1; en3_n = 0;
        cyc();
        chk("R2 both addr", word_addr_o, c);
        chk("R2 both sel", sel_o, 1);
        @(negedge clk);
        en2 = 0;
        cyc();
        chk("R4 en2 low desel", sel_o, 0);
        chk("R11 back-to-back", new_acc_o, 1);
        idle_in();
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        addr_i = 21'h00007; strb_ctrl_n = 0; en1_n = 0; en2 = 1; en3_n = 0;
        cyc();
        @(negedge clk);
        strb_ctrl_n = 1; adv_n = 0; rst = 1;
        cyc();
        chk("R9 mid addr", word_addr_o, '0);
        chk("R9 mid sel", sel_o, 0);
        chk("R9 mid pulse", new_acc_o, 0);
        @(negedge clk); rst = 0; adv_n = 1;
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_hold();
        t_gate();
        t_prio();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule